// File: doc/BRIEF.md
# Precision-Aliased Floating-Point Register File

This block stores floating-point operands as a single array of 32-bit words and exposes that array through three overlapping views: 32-bit single, 64-bit double and 128-bit quad registers. A double covers two adjacent words and a quad covers four adjacent words. Writing through one view is therefore visible at once through the others. In every view the lowest-numbered word carries the most significant bits.

An `ext_mode` input selects between two configurations. The base configuration holds 16 doubles, which is 32 words. The extended configuration adds an upper bank of 16 more doubles, which is another 32 words. Singles can never reach the upper bank. In extended mode the low bit of the 5-bit register field on a double or quad access becomes the top address bit. Each access is checked against its precision. A misaligned register number or the reserved precision code raises a fault and blocks the write.

The block has one write port and `NUM_RD` independent read ports. A read presents its data, valid bit and fault bit one clock after the request. Read data is right-justified and zero-extended to 128 bits.

Top module: `fp_alias_regfile`

## Requirements
- R1: Precision code 0 selects a single. Single n (0..31) is word n. A single write changes only that word. A single read returns the word in bits [31:0], with bits [127:32] zero.
- R2: Precision code 1 selects a double. In base mode, double register number 2n covers words 2n and 2n+1. The read returns word 2n in bits [63:32] and word 2n+1 in bits [31:0], with the upper bits zero. A double write takes its data from bits [63:0] in the same order.
- R3: Precision code 2 selects a quad. In base mode, quad register number 4m covers words 4m..4m+3, with word 4m in bits [127:96] and word 4m+3 in bits [31:0]. All four words are written in the same cycle.
- R4: In base mode, these accesses fault: a double with an odd register number, and a quad with a register number that is not a multiple of 4. A faulting write changes no word.
- R5: In extended mode, a double with field r covers words 2*d and 2*d+1, where d = 16*r[0] + r[4:1]. This never faults. Singles reach only words 0..31.
- R6: In extended mode, a quad with field r faults when r[1] is 1. Otherwise it covers words 4*q..4*q+3, where q = 8*r[0] + r[4:2].
- R7: Precision code 3 is reserved. It faults on both reads and writes, and such a write changes nothing.
- R8: A read request on port p raises rd_valid[p] in the next cycle. rd_fault[p] is also raised then if the request faulted. A faulted or idle port returns all-zero data.
- R9: A read issued in the same cycle as a write to an overlapping word returns the old contents. A read issued in the following cycle returns the new contents.
- R10: After a synchronous reset, wr_fault, every rd_valid, every rd_fault and all rd_data bits are zero.
- R11: Read ports are independent. Two ports may address different precisions and registers in the same cycle, and each gets its own result.
- R12: wr_fault is high one cycle after a faulting write request, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | 1 selects the extended configuration (32 doubles) |
| wr_en | input | 1 | Write request |
| wr_prec | input | 2 | Write precision: 0 single, 1 double, 2 quad, 3 reserved |
| wr_reg | input | REG_W | Write register field |
| wr_data | input | 4*WORD_W | Write data, right-justified |
| wr_fault | output | 1 | Previous cycle's write was rejected |
| rd_en | input | NUM_RD | Read request per port |
| rd_prec | input | 2*NUM_RD | Read precision per port, port p at [2p+1:2p] |
| rd_reg | input | REG_W*NUM_RD | Read register field per port |
| rd_valid | output | NUM_RD | Read result present |
| rd_fault | output | NUM_RD | Read request was illegal |
| rd_data | output | 4*WORD_W*NUM_RD | Read data per port, right-justified |

## Verification
The bench aims at the seams between views. It reads a double or quad right after a single write inside it, which catches a design that writes whole rows or swaps word order. It uses odd and non-multiple-of-4 register numbers in both modes, which exposes a design that applies the base-mode alignment rule in extended mode, or that lets a faulting write through. It toggles the mode while accessing field values with bit 0 set, so a missing upper-bank remap reads the lower bank instead. It also issues a read and a write to the same word in one cycle, so a design that bypasses, or that lags by a cycle, returns the wrong generation of data.

// File: rtl/fprf_pkg.sv
package fprf_pkg;
  localparam int LANES = 4;  // words per quad

  typedef enum logic [1:0] {
    PREC_S = 2'd0,
    PREC_D = 2'd1,
    PREC_Q = 2'd2,
    PREC_X = 2'd3
  } prec_e;
endpackage

// File: rtl/fprf_addr_dec.sv
// Maps a precision and register field onto a word index and a fault bit.
module fprf_addr_dec
  import fprf_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [1:0]       prec,
  input  logic [REG_W-1:0] regn,
  input  logic             ext,
  output logic [REG_W:0]   widx,
  output logic             fault
);
  always_comb begin
    widx  = '0;
    fault = 1'b0;
    case (prec_e'(prec))
      PREC_S: widx = {1'b0, regn};
      PREC_D: begin
        if (ext) begin
          widx = {regn[0], regn[REG_W-1:1], 1'b0};
        end else begin
          widx  = {1'b0, regn[REG_W-1:1], 1'b0};
          fault = regn[0];
        end
      end
      PREC_Q: begin
        if (ext) begin
          widx  = {regn[0], regn[REG_W-1:2], 2'b00};
          fault = regn[1];
        end else begin
          widx  = {1'b0, regn[REG_W-1:2], 2'b00};
          fault = |regn[1:0];
        end
      end
      default: fault = 1'b1;
    endcase
  end
endmodule

// File: rtl/fprf_lane.sv
// One word lane: simple RAM, one write port, NUM_RD registered reads.
module fprf_lane #(
  parameter int WORD_W = 32,
  parameter int ROWS   = 16,
  parameter int AW     = 4,
  parameter int NUM_RD = 2
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [WORD_W-1:0]        wdata,
  input  logic [NUM_RD*AW-1:0]     raddr,
  output logic [NUM_RD*WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk) begin
      q <= mem[raddr[p*AW +: AW]];
    end
    assign rdata[p*WORD_W +: WORD_W] = q;
  end
endmodule

// File: rtl/fprf_rd_align.sv
// Packs registered lane words into a right-justified result.
module fprf_rd_align
  import fprf_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [LANES*WORD_W-1:0] lanes,
  input  logic [1:0]              prec,
  input  logic [1:0]              sub,
  input  logic                    en,
  output logic [LANES*WORD_W-1:0] data
);
  logic [WORD_W-1:0] lw [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_w
    assign lw[k] = lanes[k*WORD_W +: WORD_W];
  end

  always_comb begin
    data = '0;
    if (en) begin
      case (prec_e'(prec))
        PREC_Q: data = {lw[0], lw[1], lw[2], lw[3]};
        PREC_D: data[2*WORD_W-1:0] = sub[1] ? {lw[2], lw[3]} : {lw[0], lw[1]};
        PREC_S: data[WORD_W-1:0] = lw[sub];
        default: data = '0;
      endcase
    end
  end
endmodule

// File: rtl/fp_alias_regfile.sv
// Word-lane register file with single/double/quad aliased views.
module fp_alias_regfile
  import fprf_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int REG_W  = 5,
  parameter int NUM_RD = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           ext_mode,
  input  logic                           wr_en,
  input  logic [1:0]                     wr_prec,
  input  logic [REG_W-1:0]               wr_reg,
  input  logic [LANES*WORD_W-1:0]        wr_data,
  output logic                           wr_fault,
  input  logic [NUM_RD-1:0]              rd_en,
  input  logic [2*NUM_RD-1:0]            rd_prec,
  input  logic [REG_W*NUM_RD-1:0]        rd_reg,
  output logic [NUM_RD-1:0]              rd_valid,
  output logic [NUM_RD-1:0]              rd_fault,
  output logic [LANES*WORD_W*NUM_RD-1:0] rd_data
);
  localparam int IDX_W = REG_W + 1;
  localparam int AW    = IDX_W - 2;
  localparam int ROWS  = (2 ** IDX_W) / LANES;
  localparam int DW    = LANES * WORD_W;

  // ---------------- write side ----------------
  logic [IDX_W-1:0] w_idx;
  logic             w_bad;
  logic             w_ok;
  logic [LANES-1:0] lane_we;
  logic [WORD_W-1:0] lane_wd [LANES];

  fprf_addr_dec #(.REG_W(REG_W)) u_wdec (
    .prec (wr_prec),
    .regn (wr_reg),
    .ext  (ext_mode),
    .widx (w_idx),
    .fault(w_bad)
  );

  assign w_ok = wr_en & ~w_bad;

  always_comb begin
    lane_we = '0;
    if (w_ok) begin
      case (prec_e'(wr_prec))
        PREC_S:  lane_we[w_idx[1:0]] = 1'b1;
        PREC_D:  lane_we = w_idx[1] ? 4'b1100 : 4'b0011;
        PREC_Q:  lane_we = 4'b1111;
        default: lane_we = '0;
      endcase
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_wd
    always_comb begin
      case (prec_e'(wr_prec))
        PREC_Q: lane_wd[k] = wr_data[(LANES-1-k)*WORD_W +: WORD_W];
        PREC_D: begin
          if ((k % 2) == 0) lane_wd[k] = wr_data[2*WORD_W-1:WORD_W];
          else              lane_wd[k] = wr_data[WORD_W-1:0];
        end
        default: lane_wd[k] = wr_data[WORD_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wr_fault <= 1'b0;
    else     wr_fault <= wr_en & w_bad;
  end

  // ---------------- read address decode ----------------
  logic [NUM_RD*AW-1:0]     rows_all;
  logic [NUM_RD*WORD_W-1:0] lane_q [LANES];

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rdec
    logic [IDX_W-1:0] r_idx;
    logic             r_bad;
    logic             v_q;
    logic             f_q;
    logic [1:0]       prec_q;
    logic [1:0]       sub_q;
    logic [DW-1:0]    gathered;

    fprf_addr_dec #(.REG_W(REG_W)) u_rdec (
      .prec (rd_prec[2*p +: 2]),
      .regn (rd_reg[REG_W*p +: REG_W]),
      .ext  (ext_mode),
      .widx (r_idx),
      .fault(r_bad)
    );

    assign rows_all[p*AW +: AW] = r_idx[IDX_W-1:2];

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q    <= 1'b0;
        f_q    <= 1'b0;
        prec_q <= 2'd0;
        sub_q  <= 2'd0;
      end else begin
        v_q    <= rd_en[p];
        f_q    <= rd_en[p] & r_bad;
        prec_q <= rd_prec[2*p +: 2];
        sub_q  <= r_idx[1:0];
      end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_gat
      assign gathered[k*WORD_W +: WORD_W] = lane_q[k][p*WORD_W +: WORD_W];
    end

    fprf_rd_align #(.WORD_W(WORD_W)) u_align (
      .lanes(gathered),
      .prec (prec_q),
      .sub  (sub_q),
      .en   (v_q & ~f_q),
      .data (rd_data[p*DW +: DW])
    );

    assign rd_valid[p] = v_q;
    assign rd_fault[p] = f_q;
  end

  // ---------------- storage lanes ----------------
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    fprf_lane #(
      .WORD_W(WORD_W),
      .ROWS  (ROWS),
      .AW    (AW),
      .NUM_RD(NUM_RD)
    ) u_lane (
      .clk  (clk),
      .we   (lane_we[k]),
      .waddr(w_idx[IDX_W-1:2]),
      .wdata(lane_wd[k]),
      .raddr(rows_all),
      .rdata(lane_q[k])
    );
  end
endmodule

// File: rtl/fp_alias_regfile_chk.sv
module fp_alias_regfile_chk #(
  parameter int WORD_W = 32,
  parameter int REG_W  = 5,
  parameter int NUM_RD = 2
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          ext_mode,
  input logic                          wr_en,
  input logic [1:0]                    wr_prec,
  input logic [REG_W-1:0]              wr_reg,
  input logic                          wr_fault,
  input logic [NUM_RD-1:0]             rd_en,
  input logic [2*NUM_RD-1:0]           rd_prec,
  input logic [NUM_RD-1:0]             rd_valid,
  input logic [NUM_RD-1:0]             rd_fault,
  input logic [4*WORD_W*NUM_RD-1:0]    rd_data
);
  localparam int DW = 4 * WORD_W;

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (!wr_fault && rd_valid == '0 && rd_fault == '0 && rd_data == '0));

  a_r4_base_odd_double: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ext_mode && wr_prec == 2'd1 && wr_reg[0]) |=> wr_fault);

  a_r5_ext_double_legal: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ext_mode && wr_prec == 2'd1) |=> !wr_fault);

  a_r6_ext_quad_bit1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ext_mode && wr_prec == 2'd2) |=> (wr_fault == $past(wr_reg[1])));

  a_r12_fault_needs_req: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !wr_fault);

  for (genvar p = 0; p < NUM_RD; p++) begin : g_p
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
      rd_en[p] |=> rd_valid[p]);
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !rd_en[p] |=> (!rd_valid[p] && rd_data[p*DW +: DW] == '0));
    a_r8_fault_zero: assert property (@(posedge clk) disable iff (rst)
      rd_fault[p] |-> (rd_valid[p] && rd_data[p*DW +: DW] == '0));
    a_r7_reserved_code: assert property (@(posedge clk) disable iff (rst)
      (rd_en[p] && rd_prec[2*p +: 2] == 2'd3) |=> rd_fault[p]);
    a_r1_single_zext: assert property (@(posedge clk) disable iff (rst)
      (rd_en[p] && rd_prec[2*p +: 2] == 2'd0) |=>
        (!rd_fault[p] && rd_data[p*DW+WORD_W +: DW-WORD_W] == '0));
  end
endmodule

bind fp_alias_regfile fp_alias_regfile_chk #(
  .WORD_W(WORD_W),
  .REG_W (REG_W),
  .NUM_RD(NUM_RD)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ext_mode(ext_mode),
  .wr_en   (wr_en),
  .wr_prec (wr_prec),
  .wr_reg  (wr_reg),
  .wr_fault(wr_fault),
  .rd_en   (rd_en),
  .rd_prec (rd_prec),
  .rd_valid(rd_valid),
  .rd_fault(rd_fault),
  .rd_data (rd_data)
);

// File: tb/fp_alias_regfile_tb.sv
module fp_alias_regfile_tb;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ext_mode = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_prec = '0;
  logic [4:0]   wr_reg = '0;
  logic [127:0] wr_data = '0;
  logic         wr_fault;
  logic [1:0]   rd_en = '0;
  logic [3:0]   rd_prec = '0;
  logic [9:0]   rd_reg = '0;
  logic [1:0]   rd_valid;
  logic [1:0]   rd_fault;
  logic [255:0] rd_data;

  int total = 0;
  int bad = 0;
  logic [31:0] m [64];

  always #(CLK_P/2) clk = ~clk;

  fp_alias_regfile #(.WORD_W(32), .REG_W(5), .NUM_RD(2)) u_dut (
    .clk(clk), .rst(rst), .ext_mode(ext_mode),
    .wr_en(wr_en), .wr_prec(wr_prec), .wr_reg(wr_reg), .wr_data(wr_data),
    .wr_fault(wr_fault),
    .rd_en(rd_en), .rd_prec(rd_prec), .rd_reg(rd_reg),
    .rd_valid(rd_valid), .rd_fault(rd_fault), .rd_data(rd_data)
  );

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // Reference address map taken from R1..R7
  function automatic int ref_word(input logic [1:0] p, input logic [4:0] r,
                                  input logic ext, output bit flt);
    int n;
    flt = 1'b0;
    n = int'(r);
    case (p)
      2'd0: return n;
      2'd1: begin
        if (ext) return 2 * ((r[0] ? 16 : 0) + (n / 2));
        flt = (n % 2) != 0;
        return n;
      end
      2'd2: begin
        if (ext) begin
          flt = r[1];
          return 4 * ((r[0] ? 8 : 0) + (n / 4));
        end
        flt = (n % 4) != 0;
        return 4 * (n / 4);
      end
      default: begin
        flt = 1'b1;
        return 0;
      end
    endcase
  endfunction

  function automatic logic [127:0] ref_read(input logic [1:0] p, input logic [4:0] r,
                                            output bit flt);
    int w;
    w = ref_word(p, r, ext_mode, flt);
    if (flt) return '0;
    case (p)
      2'd0: return {96'd0, m[w]};
      2'd1: return {64'd0, m[w], m[w+1]};
      default: return {m[w], m[w+1], m[w+2], m[w+3]};
    endcase
  endfunction

  function automatic bit ref_write(input logic [1:0] p, input logic [4:0] r,
                                   input logic [127:0] d);
    int w;
    bit flt;
    w = ref_word(p, r, ext_mode, flt);
    if (flt) return 1'b1;
    case (p)
      2'd0: m[w] = d[31:0];
      2'd1: begin m[w] = d[63:32]; m[w+1] = d[31:0]; end
      default: begin
        m[w] = d[127:96]; m[w+1] = d[95:64]; m[w+2] = d[63:32]; m[w+3] = d[31:0];
      end
    endcase
    return 1'b0;
  endfunction

  // One cycle: drive at negedge, result sampled at the following negedge.
  task automatic step(input string tag, input bit we, input logic [1:0] wp,
                      input logic [4:0] wr, input logic [127:0] wd,
                      input bit re0, input logic [1:0] p0, input logic [4:0] r0,
                      input bit re1, input logic [1:0] p1, input logic [4:0] r1);
    logic [127:0] e0, e1;
    bit f0, f1, wf;
    wr_en = we; wr_prec = wp; wr_reg = wr; wr_data = wd;
    rd_en = {re1, re0}; rd_prec = {p1, p0}; rd_reg = {r1, r0};
    e0 = ref_read(p0, r0, f0);
    e1 = ref_read(p1, r1, f1);
    if (!re0) begin e0 = '0; f0 = 1'b0; end
    if (!re1) begin e1 = '0; f1 = 1'b0; end
    wf = we ? ref_write(wp, wr, wd) : 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "wr_fault", {127'd0, wr_fault}, {127'd0, wf});
    if (re0) begin
      chk(tag, "valid0", {127'd0, rd_valid[0]}, 128'd1);
      chk(tag, "fault0", {127'd0, rd_fault[0]}, {127'd0, f0});
      chk(tag, "data0", rd_data[127:0], e0);
    end
    if (re1) begin
      chk(tag, "valid1", {127'd0, rd_valid[1]}, 128'd1);
      chk(tag, "fault1", {127'd0, rd_fault[1]}, {127'd0, f1});
      chk(tag, "data1", rd_data[255:128], e1);
    end
    wr_en = 1'b0; rd_en = '0;
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0f17));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: state while reset is held
    chk("R10", "wr_fault", {127'd0, wr_fault}, 128'd0);
    chk("R10", "valid", {126'd0, rd_valid}, 128'd0);
    chk("R10", "fault", {126'd0, rd_fault}, 128'd0);
    chk("R10", "data", rd_data[127:0] | rd_data[255:128], 128'd0);
    rst = 1'b0;

    // Fill all 64 words through extended-mode quads (R6)
    ext_mode = 1'b1;
    for (int q = 0; q < 16; q++) begin
      logic [4:0] rq;
      rq = 5'((q % 8) * 4 + (q / 8));
      step("R6", 1'b1, 2'd2, rq,
           {$urandom(), $urandom(), $urandom(), $urandom()},
           1'b0, 2'd0, 5'd0, 1'b0, 2'd0, 5'd0);
    end

    ext_mode = 1'b0;
    // R1: single write changes only its word; neighbours read back intact
    step("R1", 1'b1, 2'd0, 5'd5, {96'd0, 32'hCAFE_0005}, 1'b0, 2'd0, 5'd0, 1'b0, 2'd0, 5'd0);
    step("R1", 1'b0, 2'd0, 5'd0, '0, 1'b1, 2'd0, 5'd5, 1'b1, 2'd0, 5'd4);
    // R2: double 4 = {single4, single5}
    step("R2", 1'b0, 2'd0, 5'd0, '0, 1'b1, 2'd1, 5'd4, 1'b1, 2'd0, 5'd6);
    step("R2", 1'b1, 2'd1, 5'd10, {64'd0, 64'h1111_2222_3333_4444}, 1'b0, 2'd0, 5'd0, 1'b0, 2'd0, 5'd0);
    step("R2", 1'b0, 2'd0, 5'd0, '0, 1'b1, 2'd0, 5'd10, 1'b1, 2'd0, 5'd11);
    // R3: quad 8 spans singles 8..11
    step("R3", 1'b0, 2'd0, 5'd0, '0, 1'b1, 2'd2, 5'd8, 1'b1, 2'd1, 5'd10);
    step("R3", 1'b1, 2'd2, 5'd28, 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210,
         1'b0, 2'd0, 5'd0, 1'b0, 2'd0, 5'd0);
    step("R3", 1'b0, 2'd0, 5'd0, '0, 1'b1, 2'd0, 5'd31, 1'b1, 2'd1, 5'd28);
    // R4: misaligned writes are dropped
    step("R4", 1'b1, 2'd1, 5'd3, {64'd0, 64'hDEAD_DEAD_DEAD_DEAD}, 1'b1, 2'd1, 5'd3, 1'b0, 2'd0, 5'd0);
    step("R4", 1'b1, 2'd2, 5'd6, {128{1'b1}}, 1'b1, 2'd2, 5'd2, 1'b0, 2'd0, 5'd0);
    step("R4", 1'b0, 2'd0, 5'd0, '0, 1'b1, 2'd1, 5'd2, 1'b1, 2'd2, 5'd4);
    // R5: extended double with bit0 set reaches the upper bank
    ext_mode = 1'b1;
    step("R5", 1'b1, 2'd1, 5'd1, {64'd0, 64'hAAAA_0001_BBBB_0002}, 1'b0, 2'd0, 5'd0, 1'b0, 2'd0, 5'd0);
    step("R5", 1'b0, 2'd0, 5'd0, '0, 1'b1, 2'd1, 5'd1, 1'b1, 2'd1, 5'd0);
    step("R5", 1'b0, 2'd0, 5'd0, '0, 1'b1, 2'd0, 5'd1, 1'b1, 2'd2, 5'd1);
    // R6: extended quad with bit1 set faults
    step("R6", 1'b1, 2'd2, 5'd3, {128{1'b1}}, 1'b1, 2'd2, 5'd2, 1'b1, 2'd2, 5'd1);
    // R7: reserved code
    step("R7", 1'b1, 2'd3, 5'd0, {128{1'b1}}, 1'b1, 2'd3, 5'd8, 1'b1, 2'd0, 5'd0);
    // R9: same-cycle read sees old data, next cycle sees new
    step("R9", 1'b1, 2'd0, 5'd12, {96'd0, 32'h9999_8888}, 1'b1, 2'd1, 5'd12, 1'b1, 2'd0, 5'd12);
    step("R9", 1'b0, 2'd0, 5'd0, '0, 1'b1, 2'd2, 5'd12, 1'b1, 2'd0, 5'd12);
    // R8: idle ports, one active
    step("R8", 1'b0, 2'd0, 5'd0, '0, 1'b0, 2'd0, 5'd0, 1'b1, 2'd0, 5'd3);

    // R11/R12: constrained random traffic across both modes
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 15) == 0) ext_mode = ~ext_mode;
      step("R11", $urandom_range(0, 1) == 1, 2'($urandom_range(0, 3)), 5'($urandom()),
           {$urandom(), $urandom(), $urandom(), $urandom()},
           $urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)), 5'($urandom()),
           $urandom_range(0, 3) != 0, 2'($urandom_range(0, 3)), 5'($urandom()));
    end
    step("R12", 1'b0, 2'd0, 5'd0, '0, 1'b0, 2'd0, 5'd0, 1'b0, 2'd0, 5'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule